// File: doc/BRIEF.md
# Current-Limit Set-Point Sampler

This block turns an externally programmed analog voltage into a digital overcurrent threshold. The voltage comes from a constant current flowing through a resistor on a pin that is shared with the low-side gate driver. When the start-up sequencer asks for a sample, the block holds the low-side driver off. It enables the external current source and waits a fixed settling interval. It then ramps a counter from zero, one code per step interval. An external DAC follows the counter, and an external comparator reports when the DAC output has risen above the pin voltage. The counter value at that moment is latched as the set point, and the result is marked valid. Because the conversion stops at the first comparator trip, small settings convert quickly and large settings take up to the full ramp. With the default step interval, the full ramp lasts about 3.4 ms at 100 MHz.

If the ramp reaches full scale without a trip, the pin voltage is above the usable range. This includes the case where no resistor is fitted. The block then flags protection as switched off. The held code has no analog decay and stays put until power-on reset or until a later shutdown-and-enable cycle followed by a new request. Requests made in any other situation, such as during fault retries, are ignored. While a valid and enabled set point is held, the block compares a sensed-current code from the monitor path against it. The result is a registered, qualified overcurrent flag.

Top module: `ilim_setpoint_sampler`

## Requirements
- R1: After reset, lowDrvHold, srcEn, sampleDone, ocpOff and ocTrip are 0, and setPoint and dacCode are 0.
- R2: A request that is accepted (sampleReq high at a clock edge while enable is high and the block is armed) raises lowDrvHold and srcEn from the next cycle. Both stay high until the set point is latched, and sampleDone is never high while they are high.
- R3: dacCode starts at 0 and rises by exactly one per step interval. The latched setPoint is the first code at which cmpAbove (1 = DAC output above pin voltage) is seen high at the end of a step.
- R4: sampleDone rises SETTLE_CYCLES + (setPoint+1)*STEP_CYCLES clock edges after the edge that accepted the request.
- R5: If cmpAbove is still low at the end of the step for the all-ones code, the block sets ocpOff to 1, latches setPoint as all ones, and raises sampleDone.
- R6: Once latched, setPoint, ocpOff and sampleDone do not change while enable stays high. Further requests are ignored: no driver hold, no new conversion.
- R7: Driving enable low re-arms the block. After enable returns high, a request starts a fresh conversion, and the new value replaces the old one.
- R8: If enable is low at a clock edge during a conversion, the conversion is aborted. lowDrvHold and srcEn are 0 from the next cycle, and sampleDone stays 0.
- R9: ocTrip, one cycle after an edge, equals senseStrobe AND sampleDone AND NOT ocpOff AND (senseCode > setPoint, unsigned) as seen at that edge.
- R10: A request made while enable is low does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| enable | input | 1 | High when the controller is not in shutdown |
| sampleReq | input | 1 | Sequencer request to take a set-point sample |
| cmpAbove | input | 1 | Comparator result: DAC output above pin voltage |
| senseStrobe | input | 1 | Marks senseCode as valid for this cycle (monitor window) |
| senseCode | input | CODE_W | Sensed low-side voltage drop as a code |
| lowDrvHold | output | 1 | Forces the low-side gate driver off during sampling |
| srcEn | output | 1 | Turns on the set-point current source |
| dacCode | output | CODE_W | Counter value driving the external DAC |
| setPoint | output | CODE_W | Latched overcurrent threshold code |
| sampleDone | output | 1 | Latched set point is valid |
| ocpOff | output | 1 | Pin was over range; overcurrent protection is off |
| ocTrip | output | 1 | Registered qualified overcurrent indication |

## Verification
The bench drives the comparator from a model pin level. It goes after the codes around the top of the range: a pin level one below full scale must latch all ones with protection still active, and a level at or above full scale must read as over range. A design with an off-by-one in the end-of-ramp test would confuse these two cases. It times each conversion exactly, so a ramp that skips a code, or a settle interval that is too long or too short, shows up as a wrong cycle count. It also issues requests after a capture and while disabled, aborts a conversion midway, and checks the trip flag against set points on both sides of the sensed code. A design that re-sampled during retries, left the driver held after an abort, or tripped with protection off would fail these checks.

// File: rtl/ilim_sampler_pkg.sv
package ilim_sampler_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RAMP   = 2'd2,
    ST_HOLD   = 2'd3
  } smpState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic timerClr;
    logic codeClr;
    logic codeInc;
    logic capture;
    logic markOver;
    logic invalidate;
  } smpStrobe_t;

endpackage

// File: rtl/ilim_sampler_dp.sv
module ilim_sampler_dp
  import ilim_sampler_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int SETTLE_CYCLES = 100,
  parameter int STEP_CYCLES   = 1328
) (
  input  logic              clk,
  input  logic              rstN,
  input  smpStrobe_t        stb,
  input  logic              senseStrobe,
  input  logic [CODE_W-1:0] senseCode,
  output logic              settleDone,
  output logic              stepDone,
  output logic              codeAtMax,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] setPoint,
  output logic              heldValid,
  output logic              overRange,
  output logic              ocTrip
);

  localparam int TMR_LIM = (SETTLE_CYCLES > STEP_CYCLES) ? SETTLE_CYCLES : STEP_CYCLES;
  localparam int TMR_W   = $clog2(TMR_LIM + 1);
  localparam logic [TMR_W-1:0]  SETTLE_LAST = TMR_W'(SETTLE_CYCLES - 1);
  localparam logic [TMR_W-1:0]  STEP_LAST   = TMR_W'(STEP_CYCLES - 1);
  localparam logic [CODE_W-1:0] CODE_MAX    = '1;

  logic [TMR_W-1:0]  intervalTmr;
  logic [CODE_W-1:0] rampCode;

  // interval timer shared by settle and step phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             intervalTmr <= '0;
    else if (stb.timerClr) intervalTmr <= '0;
    else                   intervalTmr <= intervalTmr + 1'b1;
  end

  assign settleDone = (intervalTmr == SETTLE_LAST);
  assign stepDone   = (intervalTmr == STEP_LAST);

  // ramp counter feeding the external DAC
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rampCode <= '0;
    else if (stb.codeClr) rampCode <= '0;
    else if (stb.codeInc) rampCode <= rampCode + 1'b1;
  end

  assign codeAtMax = (rampCode == CODE_MAX);
  assign dacCode   = rampCode;

  // held set point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setPoint  <= '0;
      heldValid <= 1'b0;
      overRange <= 1'b0;
    end else if (stb.invalidate) begin
      heldValid <= 1'b0;
      overRange <= 1'b0;
    end else if (stb.capture) begin
      setPoint  <= rampCode;
      heldValid <= 1'b1;
      overRange <= stb.markOver;
    end
  end

  // qualified threshold compare against the sensed code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ocTrip <= 1'b0;
    else       ocTrip <= senseStrobe && heldValid && !overRange && (senseCode > setPoint);
  end

endmodule

// File: rtl/ilim_sampler_ctrl.sv
module ilim_sampler_ctrl
  import ilim_sampler_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sampleReq,
  input  logic       cmpAbove,
  input  logic       settleDone,
  input  logic       stepDone,
  input  logic       codeAtMax,
  output smpStrobe_t stb,
  output logic       busy
);

  smpState_t state, stateNxt;
  logic      armed;
  logic      startOk;

  assign startOk = enable && armed && sampleReq &&
                   ((state == ST_IDLE) || (state == ST_HOLD));

  // armed on reset and whenever the part sits in shutdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b1;
    else if (!enable) armed <= 1'b1;
    else if (startOk) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    if (!enable) begin
      stateNxt     = ST_IDLE;
      stb.timerClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE, ST_HOLD: begin
          stb.timerClr = 1'b1;
          if (startOk) begin
            stateNxt       = ST_SETTLE;
            stb.codeClr    = 1'b1;
            stb.invalidate = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleDone) begin
            stateNxt     = ST_RAMP;
            stb.timerClr = 1'b1;
          end
        end
        ST_RAMP: begin
          if (stepDone) begin
            stb.timerClr = 1'b1;
            if (cmpAbove) begin
              stb.capture = 1'b1;
              stateNxt    = ST_HOLD;
            end else if (codeAtMax) begin
              stb.capture  = 1'b1;
              stb.markOver = 1'b1;
              stateNxt     = ST_HOLD;
            end else begin
              stb.codeInc = 1'b1;
            end
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_SETTLE) || (state == ST_RAMP);

endmodule

// File: rtl/ilim_setpoint_sampler.sv
module ilim_setpoint_sampler
  import ilim_sampler_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int SETTLE_CYCLES = 100,
  parameter int STEP_CYCLES   = 1328
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sampleReq,
  input  logic              cmpAbove,
  input  logic              senseStrobe,
  input  logic [CODE_W-1:0] senseCode,
  output logic              lowDrvHold,
  output logic              srcEn,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] setPoint,
  output logic              sampleDone,
  output logic              ocpOff,
  output logic              ocTrip
);

  smpStrobe_t stb;
  logic       busy;
  logic       settleDone;
  logic       stepDone;
  logic       codeAtMax;

  ilim_sampler_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sampleReq  (sampleReq),
    .cmpAbove   (cmpAbove),
    .settleDone (settleDone),
    .stepDone   (stepDone),
    .codeAtMax  (codeAtMax),
    .stb        (stb),
    .busy       (busy)
  );

  ilim_sampler_dp #(
    .CODE_W        (CODE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .STEP_CYCLES   (STEP_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .senseStrobe (senseStrobe),
    .senseCode   (senseCode),
    .settleDone  (settleDone),
    .stepDone    (stepDone),
    .codeAtMax   (codeAtMax),
    .dacCode     (dacCode),
    .setPoint    (setPoint),
    .heldValid   (sampleDone),
    .overRange   (ocpOff),
    .ocTrip      (ocTrip)
  );

  assign lowDrvHold = busy;
  assign srcEn      = busy;

endmodule

// File: rtl/ilim_setpoint_sampler_chk.sv
module ilim_setpoint_sampler_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              lowDrvHold,
  input logic              sampleDone,
  input logic              ocpOff,
  input logic              ocTrip,
  input logic [CODE_W-1:0] dacCode,
  input logic [CODE_W-1:0] setPoint
);

  AST_HOLD_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    lowDrvHold |-> !sampleDone); // R2

  AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleDone) |-> $past(lowDrvHold)); // R2

  AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (lowDrvHold && $past(lowDrvHold)) |-> (dacCode >= $past(dacCode))); // R3

  AST_OVER_FULL_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleDone && ocpOff) |-> (setPoint == {CODE_W{1'b1}})); // R5

  AST_SETPOINT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleDone && $past(sampleDone)) |-> $stable(setPoint)); // R6

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !lowDrvHold); // R8

  AST_TRIP_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    ocTrip |-> ($past(sampleDone) && !$past(ocpOff))); // R9

endmodule

bind ilim_setpoint_sampler ilim_setpoint_sampler_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .lowDrvHold (lowDrvHold),
  .sampleDone (sampleDone),
  .ocpOff     (ocpOff),
  .ocTrip     (ocTrip),
  .dacCode    (dacCode),
  .setPoint   (setPoint)
);

// File: tb/ilim_setpoint_sampler_bench.sv
module ilim_setpoint_sampler_bench;

  localparam int CW     = 8;
  localparam int SETTLE = 5;
  localparam int STEP   = 3;
  localparam int FULL   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          sampleReq = 1'b0;
  logic          senseStrobe = 1'b0;
  logic [CW-1:0] senseCode = '0;
  logic          cmpAbove;
  logic          lowDrvHold, srcEn, sampleDone, ocpOff, ocTrip;
  logic [CW-1:0] dacCode, setPoint;

  int pinLevel = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // comparator model: DAC above pin level
  assign cmpAbove = (int'(dacCode) > pinLevel);

  ilim_setpoint_sampler #(
    .CODE_W(CW), .SETTLE_CYCLES(SETTLE), .STEP_CYCLES(STEP)
  ) u_ilim_setpoint_sampler (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleReq(sampleReq),
    .cmpAbove(cmpAbove), .senseStrobe(senseStrobe), .senseCode(senseCode),
    .lowDrvHold(lowDrvHold), .srcEn(srcEn), .dacCode(dacCode),
    .setPoint(setPoint), .sampleDone(sampleDone), .ocpOff(ocpOff), .ocTrip(ocTrip)
  );

  function automatic int expCode(input int pin);
    return (pin >= FULL) ? FULL : pin + 1;
  endfunction

  function automatic bit expOver(input int pin);
    return pin >= FULL;
  endfunction

  function automatic int expEdges(input int pin);
    return 1 + SETTLE + (expCode(pin) + 1) * STEP;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rearm();
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
  endtask

  task automatic doSample(input int pin);
    int n = 0;
    pinLevel = pin;
    @(negedge clk) sampleReq = 1'b1;
    while (n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) begin
        sampleReq = 1'b0;
        chk(lowDrvHold && srcEn, "R2 hold+source after accept", int'(lowDrvHold && srcEn), 1);
      end
      if (sampleDone) break;
    end
    chk(n == expEdges(pin), "R4 conversion edges", n, expEdges(pin));
    chk(int'(setPoint) == expCode(pin), "R3 latched code", int'(setPoint), expCode(pin));
    chk(ocpOff == expOver(pin), "R5 over-range flag", int'(ocpOff), int'(expOver(pin)));
    chk(!lowDrvHold && !srcEn, "R2 release on done", int'(lowDrvHold || srcEn), 0);
  endtask

  task automatic tripCheck(input bit strobe, input int code);
    bit exp;
    exp = strobe && sampleDone && !ocpOff && (code > int'(setPoint));
    @(negedge clk);
    senseStrobe = strobe;
    senseCode   = CW'(code);
    @(negedge clk);
    chk(ocTrip == exp, "R9 qualified trip", int'(ocTrip), int'(exp));
    senseStrobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!lowDrvHold && !srcEn && !sampleDone && !ocpOff && !ocTrip, "R1 reset flags",
        int'({lowDrvHold, srcEn, sampleDone, ocpOff, ocTrip}), 0);
    chk(setPoint == 0 && dacCode == 0, "R1 reset codes", int'(setPoint), 0);
    rstN = 1'b1;

    // R10 request while disabled
    @(negedge clk) sampleReq = 1'b1;
    repeat (3) @(negedge clk);
    sampleReq = 1'b0;
    chk(!lowDrvHold && !sampleDone, "R10 request while disabled", int'(lowDrvHold), 0);

    enable = 1'b1;
    @(negedge clk);
    doSample(40);

    // R6 later request ignored
    held = int'(setPoint);
    pinLevel = 10;
    @(negedge clk) sampleReq = 1'b1;
    @(negedge clk) sampleReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(!lowDrvHold && sampleDone && int'(setPoint) == held, "R6 retry request ignored",
        int'(setPoint), held);

    tripCheck(1'b1, held + 1);
    tripCheck(1'b1, held);
    tripCheck(1'b0, FULL);
    for (int i = 0; i < 6; i++) tripCheck(1'b1, int'($urandom_range(0, FULL)));

    // R7 re-arm gives a fresh conversion; directed corners
    rearm(); doSample(0);
    chk(int'(setPoint) == 1, "R7 new value after re-enable", int'(setPoint), 1);
    rearm(); doSample(FULL - 1);
    tripCheck(1'b1, FULL);
    rearm(); doSample(FULL);
    tripCheck(1'b1, FULL);
    rearm(); doSample(300);

    // random pin levels
    for (int i = 0; i < 6; i++) begin
      rearm();
      doSample(int'($urandom_range(0, 270)));
      tripCheck(1'b1, int'($urandom_range(0, FULL)));
    end

    // R8 abort during ramp
    rearm();
    pinLevel = 200;
    @(negedge clk) sampleReq = 1'b1;
    @(negedge clk) sampleReq = 1'b0;
    repeat (20) @(negedge clk);
    chk(lowDrvHold, "R8 busy before abort", int'(lowDrvHold), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!lowDrvHold && !srcEn && !sampleDone, "R8 abort releases driver",
        int'({lowDrvHold, srcEn, sampleDone}), 0);
    repeat (5) @(negedge clk);
    chk(!sampleDone, "R8 no capture after abort", int'(sampleDone), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule